// File: doc/BRIEF.md
# GPIO Edge Interrupt Controller with Per-Core Steering

This block watches a bank of 32 general-purpose input lines, grouped as four ports of eight lines each, and turns selected edges on them into interrupt requests. Every line has a two-bit trigger selector, and a sticky pending bit that software acknowledges by writing ones. A separate per-core routing mask decides which cores see a pending line. Each core has its own level interrupt output.

Software reaches the block over a simple single-cycle bus with byte enables and two address regions. The control region holds the trigger selectors and the pending bits. The routing region holds one 32-bit word per core, with one byte per port. Reads return the stored values, so one line's routing or trigger can be changed by read-modify-write without touching its neighbours. The number of cores follows from the size of the routing region. A build-time option mirrors the placement of the ports inside each word.

Top module: `gpio_irq_route`

## Requirements
- R1: Line n belongs to port n/8 at bit n%8. With the default layout, port p occupies byte lane p (bits 8p+7..8p) of the pending word (control word 2) and of each routing word.
- R2: Trigger field values are 00 off, 01 falling edge, 10 rising edge, 11 both edges. Control word 0 holds ports 0 and 1 and word 1 holds ports 2 and 3, with the lower port of each pair in bits 15..0 by default and pin k of a port in bits 2k+1..2k of its half. Inputs pass through two synchronising flops, so a pending bit becomes visible on the third rising clock edge after the input changes.
- R3: Writing a one to a bit of control word 2, in a byte whose byte enable is set, clears that pending bit. Zero bits and disabled byte lanes have no effect.
- R4: When a new qualifying edge and a clear of the same pending bit fall in the same cycle, the bit stays set.
- R5: Every routing mask resets to all ones. The routing region holds core c's mask at word c (byte address 4c plus the port's lane), and a line reaches core c only if its bit in that word is one.
- R6: irq_o[c] is high exactly when some line is pending, has a non-zero trigger field, and has its routing bit for core c set. The output is a level that holds until software changes that state by a write.
- R7: With REVERSED set, port p sits in byte lane 3-p of the pending word and routing words. In the trigger words the halves are swapped: port 1 sits in bits 15..0 and port 0 in bits 31..16 of word 0, and port 3 sits in bits 15..0 and port 2 in bits 31..16 of word 1.
- R8: The core count is the routing-region size in bytes divided by four. Routing words at or beyond that count, and control word 3, read as zero and ignore writes.
- R9: Reads of control words 0 to 2 and of the routing words return the current trigger fields, pending bits and masks.
- R10: A line whose trigger field is 00 never becomes pending, whatever its input does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| gpio_i | input | 32 | Asynchronous input lines |
| bus_wr_i | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_region_i | input | 1 | 0 selects the control region, 1 the routing region |
| bus_addr_i | input | ADDR_W | Word address within the selected region |
| bus_be_i | input | 4 | Byte enables for writes |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Combinational read data for the addressed word |
| irq_o | output | NUM_CPUS | One level interrupt per core |

## Verification
The bench toggles random subsets of the inputs under random trigger fields, random masks and random byte-enabled writes. This separates edge polarity errors, lane and half mapping errors, and routing errors, because each one shows up in a different readback word or core output. Directed cases set the exact arrival cycle of a synchronised edge and the collision of an edge with a clear in the same cycle. Other directed cases cover disabled lines, clears in the wrong lane, unmapped words, and a second instance built with the mirrored layout, whose readback and per-core outputs must differ from the default one in the predicted places.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int PORTS  = 4;
  localparam int PINS   = 8;
  localparam int LINES  = PORTS * PINS;
  localparam int LANES  = 4;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    TRIG_OFF  = 2'b00,
    TRIG_FALL = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_BOTH = 2'b11
  } trig_e;

  // byte lane that carries port p in 8-bit-per-pin words
  function automatic int lane_of_port(int p, int rev);
    return (rev != 0) ? (LANES - 1 - p) : p;
  endfunction

  // port held by half h of trigger word w
  function automatic int port_of_half(int w, int h, int rev);
    return 2 * w + (h ^ rev);
  endfunction
endpackage

// File: rtl/gpio_sync_edge.sv
module gpio_sync_edge
  import gpio_irq_pkg::*;
#(
  parameter int N = LINES
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   pin_i,
  input  logic [2*N-1:0] trig_i,
  output logic [N-1:0]   evt_o
);
  logic [N-1:0] meta_q, sync_q, prev_q;
  logic [N-1:0] meta_d, sync_d, prev_d;
  logic [N-1:0] rise, fall;

  always_comb begin
    meta_d = pin_i;
    sync_d = meta_q;
    prev_d = sync_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign rise = sync_q & ~prev_q;
  assign fall = ~sync_q & prev_q;

  for (genvar n = 0; n < N; n++) begin : g_line
    trig_e t;
    assign t = trig_e'(trig_i[2*n +: 2]);
    assign evt_o[n] = (rise[n] && (t == TRIG_RISE || t == TRIG_BOTH)) ||
                      (fall[n] && (t == TRIG_FALL || t == TRIG_BOTH));
  end
endmodule

// File: rtl/gpio_cpu_route.sv
module gpio_cpu_route
  import gpio_irq_pkg::*;
#(
  parameter int NUM_CPUS = 2,
  parameter int ADDR_W   = 3,
  parameter bit REVERSED = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [LANES-1:0]    be_i,
  input  logic [WORD_W-1:0]   wdata_i,
  input  logic [LINES-1:0]    status_i,
  input  logic [LINES-1:0]    armed_i,
  output logic [WORD_W-1:0]   rdata_o,
  output logic [NUM_CPUS-1:0] irq_o
);
  localparam int REV_I = REVERSED ? 1 : 0;

  logic [NUM_CPUS-1:0][WORD_W-1:0] rd_words;
  logic [LINES-1:0] live;

  assign live = status_i & armed_i;

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic [LINES-1:0] mask_q, mask_d;
    logic             hit;

    assign hit = wr_i && (addr_i == ADDR_W'(c));

    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
      localparam int P = lane_of_port(i / PINS, REV_I);
      localparam int L = PINS * P + (i % PINS);
      assign mask_d[L]      = (hit && be_i[i / PINS]) ? wdata_i[i] : mask_q[L];
      assign rd_words[c][i] = mask_q[L];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mask_q <= '1;
      else if (hit) mask_q <= mask_d;
    end

    assign irq_o[c] = |(live & mask_q);
  end

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NUM_CPUS; c++) begin
      if (addr_i == ADDR_W'(c)) rdata_o = rd_words[c];
    end
  end
endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route
  import gpio_irq_pkg::*;
#(
  parameter int MASK_BYTES = 8,
  parameter int ADDR_W     = 3,
  parameter bit REVERSED   = 1'b0,
  localparam int NUM_CPUS  = MASK_BYTES / LANES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LINES-1:0]    gpio_i,
  input  logic                bus_wr_i,
  input  logic                bus_region_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [LANES-1:0]    bus_be_i,
  input  logic [WORD_W-1:0]   bus_wdata_i,
  output logic [WORD_W-1:0]   bus_rdata_o,
  output logic [NUM_CPUS-1:0] irq_o
);
  localparam int REV_I    = REVERSED ? 1 : 0;
  localparam int EN_WORDS = 2;
  localparam int ST_WORD  = 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic wr_main, wr_mask;
  assign wr_main = bus_wr_i && !bus_region_i;
  assign wr_mask = bus_wr_i &&  bus_region_i;

  // trigger fields, two bits per line, line-indexed
  logic [2*LINES-1:0] en_q, en_d;
  logic [EN_WORDS-1:0] en_hit;
  logic [EN_WORDS-1:0][WORD_W-1:0] en_word;
  logic en_ce;

  for (genvar w = 0; w < EN_WORDS; w++) begin : g_enw
    assign en_hit[w] = wr_main && (bus_addr_i == ADDR_W'(w));
    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
      localparam int P   = port_of_half(w, i / 16, REV_I);
      localparam int IDX = 2 * (PINS * P + (i % 16) / 2) + (i % 2);
      assign en_word[w][i] = en_q[IDX];
      assign en_d[IDX] = (en_hit[w] && bus_be_i[i / PINS]) ? bus_wdata_i[i] : en_q[IDX];
    end
  end
  assign en_ce = |en_hit;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) en_q <= '0;
    else if (en_ce)  en_q <= en_d;
  end

  logic [LINES-1:0] armed;
  for (genvar n = 0; n < LINES; n++) begin : g_arm
    assign armed[n] = |en_q[2*n +: 2];
  end

  // edge detection
  logic [LINES-1:0] evt;
  gpio_sync_edge #(.N(LINES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .pin_i  (gpio_i),
    .trig_i (en_q),
    .evt_o  (evt)
  );

  // sticky pending bits, write-one-to-clear, new event has priority
  logic [LINES-1:0] st_q, st_d, clr;
  logic [WORD_W-1:0] st_word;
  logic st_hit, st_ce;

  assign st_hit = wr_main && (bus_addr_i == ADDR_W'(ST_WORD));

  for (genvar i = 0; i < WORD_W; i++) begin : g_st
    localparam int P = lane_of_port(i / PINS, REV_I);
    localparam int L = PINS * P + (i % PINS);
    assign st_word[i] = st_q[L];
    assign clr[L] = st_hit && bus_be_i[i / PINS] && bus_wdata_i[i];
  end

  always_comb begin
    st_d  = (st_q & ~clr) | evt;
    st_ce = (|clr) || (|evt);
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) st_q <= '0;
    else if (st_ce)  st_q <= st_d;
  end

  // per-core routing
  logic [WORD_W-1:0] mask_rdata;
  gpio_cpu_route #(
    .NUM_CPUS (NUM_CPUS),
    .ADDR_W   (ADDR_W),
    .REVERSED (REVERSED)
  ) u_route (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .wr_i     (wr_mask),
    .addr_i   (bus_addr_i),
    .be_i     (bus_be_i),
    .wdata_i  (bus_wdata_i),
    .status_i (st_q),
    .armed_i  (armed),
    .rdata_o  (mask_rdata),
    .irq_o    (irq_o)
  );

  // read mux
  logic [WORD_W-1:0] main_rdata;
  always_comb begin
    main_rdata = '0;
    if (bus_addr_i == ADDR_W'(0))            main_rdata = en_word[0];
    else if (bus_addr_i == ADDR_W'(1))       main_rdata = en_word[1];
    else if (bus_addr_i == ADDR_W'(ST_WORD)) main_rdata = st_word;
    bus_rdata_o = bus_region_i ? mask_rdata : main_rdata;
  end
endmodule

// File: rtl/gpio_irq_route_chk.sv
module gpio_irq_route_chk
  import gpio_irq_pkg::*;
#(
  parameter int NUM_CPUS = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_wr,
  input logic [LINES-1:0]    evt,
  input logic [LINES-1:0]    status,
  input logic [LINES-1:0]    armed,
  input logic [NUM_CPUS-1:0] irq
);
  // R4: an edge always lands in the pending bits, even against a clear
  a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((status & $past(evt)) == $past(evt)));

  // R10: pending bits only appear from a detected edge
  a_r10_set_from_event: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~$past(status) & ~$past(evt)) == '0));

  // R10: no edge is reported on a line whose trigger field is off
  a_r10_event_needs_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt & ~armed) == '0));

  // R6: a core output needs a pending, enabled line
  a_r6_irq_needs_live_line: assert property (@(posedge clk) disable iff (!rst_n)
    (irq != '0) |-> ((status & armed) != '0));

  // R6: a core output drops only after a bus write
  a_r6_irq_held_until_write: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(irq) & ~irq) != '0) |-> $past(bus_wr));
endmodule

bind gpio_irq_route gpio_irq_route_chk #(.NUM_CPUS(NUM_CPUS)) u_chk (
  .clk    (clk),
  .rst_n  (rst_core_n),
  .bus_wr (bus_wr_i),
  .evt    (evt),
  .status (st_q),
  .armed  (armed),
  .irq    (irq_o)
);

// File: tb/gpio_irq_route_tb.sv
`timescale 1ns/1ps
module gpio_irq_route_tb;
  localparam int NCPU = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] gpio;
  logic        b_wr, b_reg;
  logic [2:0]  b_addr;
  logic [3:0]  b_be;
  logic [31:0] b_wd;
  logic [31:0] rdata_n, rdata_r;
  logic [NCPU-1:0] irq_n, irq_r;

  always #10 clk = ~clk;

  gpio_irq_route #(.MASK_BYTES(8), .ADDR_W(3), .REVERSED(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .gpio_i(gpio), .bus_wr_i(b_wr), .bus_region_i(b_reg),
    .bus_addr_i(b_addr), .bus_be_i(b_be), .bus_wdata_i(b_wd),
    .bus_rdata_o(rdata_n), .irq_o(irq_n));

  gpio_irq_route #(.MASK_BYTES(8), .ADDR_W(3), .REVERSED(1'b1)) u_rev (
    .clk(clk), .rst_n(rst_n), .gpio_i(gpio), .bus_wr_i(b_wr), .bus_region_i(b_reg),
    .bus_addr_i(b_addr), .bus_be_i(b_be), .bus_wdata_i(b_wd),
    .bus_rdata_o(rdata_r), .irq_o(irq_r));

  int n_chk = 0;
  int n_fail = 0;

  // reference model of the default-layout instance
  logic [1:0]  m_en [32];
  logic [31:0] m_st;
  logic [31:0] m_mask [NCPU];
  logic [31:0] rd_n, rd_r;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int n = 0; n < 32; n++) m_en[n] = 2'b00;
    m_st = '0;
    for (int c = 0; c < NCPU; c++) m_mask[c] = '1;
  endfunction

  function automatic void model_write(bit region, int addr, logic [3:0] be, logic [31:0] d);
    for (int i = 0; i < 32; i++) begin
      if (be[i/8]) begin
        if (!region) begin
          if (addr < 2) m_en[8*(2*addr + i/16) + (i%16)/2][i%2] = d[i];
          else if (addr == 2 && d[i]) m_st[i] = 1'b0;
        end else if (addr < NCPU) begin
          m_mask[addr][i] = d[i];
        end
      end
    end
  endfunction

  function automatic void model_pins(logic [31:0] old_p, logic [31:0] new_p);
    for (int n = 0; n < 32; n++) begin
      if (!old_p[n] && new_p[n] && m_en[n][1]) m_st[n] = 1'b1;
      if (old_p[n] && !new_p[n] && m_en[n][0]) m_st[n] = 1'b1;
    end
  endfunction

  function automatic logic [31:0] exp_read(bit region, int addr);
    logic [31:0] r = '0;
    if (!region) begin
      if (addr < 2) for (int i = 0; i < 32; i++) r[i] = m_en[8*(2*addr + i/16) + (i%16)/2][i%2];
      else if (addr == 2) r = m_st;
    end else if (addr < NCPU) begin
      r = m_mask[addr];
    end
    return r;
  endfunction

  function automatic logic [NCPU-1:0] exp_irq();
    logic [NCPU-1:0] r;
    logic [31:0] armed;
    for (int n = 0; n < 32; n++) armed[n] = |m_en[n];
    for (int c = 0; c < NCPU; c++) r[c] = |(m_st & armed & m_mask[c]);
    return r;
  endfunction

  task automatic bus_write(input bit region, input int addr, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    b_wr = 1'b1; b_reg = region; b_addr = 3'(addr); b_be = be; b_wd = d;
    @(negedge clk);
    b_wr = 1'b0;
    model_write(region, addr, be, d);
  endtask

  task automatic bus_read(input bit region, input int addr);
    @(negedge clk);
    b_reg = region; b_addr = 3'(addr);
    #1;
    rd_n = rdata_n;
    rd_r = rdata_r;
  endtask

  task automatic pins_set(input logic [31:0] v);
    @(negedge clk);
    model_pins(gpio, v);
    gpio = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    for (int a = 0; a < 4; a++) begin
      bus_read(1'b0, a);
      chk(rd_n == exp_read(1'b0, a), (a == 3) ? "R8 unmapped control word" : {tag, " R9 control readback"},
          rd_n, exp_read(1'b0, a));
    end
    for (int a = 0; a < 3; a++) begin
      bus_read(1'b1, a);
      chk(rd_n == exp_read(1'b1, a), (a >= NCPU) ? "R8 routing word beyond core count" : {tag, " R5 routing readback"},
          rd_n, exp_read(1'b1, a));
    end
    chk(irq_n == exp_irq(), {tag, " R6 core outputs"}, 32'(irq_n), 32'(exp_irq()));
  endtask

  task automatic do_reset();
    rst_n = 1'b0; gpio = '0;
    b_wr = 1'b0; b_reg = 1'b0; b_addr = '0; b_be = '0; b_wd = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'd7321);
    do_reset();

    // reset state: R5 masks all ones, nothing pending
    check_all("reset");

    // R2: line 3 rising; pending exactly on third edge after the change
    bus_write(1'b0, 0, 4'b0001, 32'h0000_0080);
    @(negedge clk);
    gpio[3] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(irq_n == 2'b00, "R2 not pending before third edge", 32'(irq_n), 32'h0);
    @(negedge clk);
    chk(irq_n == 2'b11, "R2 pending on third edge", 32'(irq_n), 32'h3);
    m_st[3] = 1'b1;
    check_all("R1 R2 rise line3");

    // R5: remove line 3 from core 1
    bus_write(1'b1, 1, 4'b0001, 32'h0000_00F7);
    chk(irq_n == 2'b01, "R5 core1 mask bit cleared", 32'(irq_n), 32'h1);

    // R3: zero data and wrong lane do nothing; right lane clears
    bus_write(1'b0, 2, 4'b1111, 32'h0);
    bus_write(1'b0, 2, 4'b0010, 32'h0000_0808);
    bus_read(1'b0, 2);
    chk(rd_n == 32'h8, "R3 clear ignored for zero bits and disabled lane", rd_n, 32'h8);
    bus_write(1'b0, 2, 4'b0001, 32'h0000_0008);
    bus_read(1'b0, 2);
    chk(rd_n == 32'h0, "R3 clear by writing one", rd_n, 32'h0);
    chk(irq_n == 2'b00, "R6 output drops after clear", 32'(irq_n), 32'h0);

    // R4: falling edge on line 3 coincides with a clear of bit 3
    bus_write(1'b0, 0, 4'b0001, 32'h0000_00C0);
    @(negedge clk);
    gpio[3] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    b_wr = 1'b1; b_reg = 1'b0; b_addr = 3'd2; b_be = 4'b0001; b_wd = 32'h8;
    @(negedge clk);
    b_wr = 1'b0;
    m_st[3] = 1'b1;
    bus_read(1'b0, 2);
    chk(rd_n == 32'h8, "R4 new edge wins over clear", rd_n, 32'h8);
    bus_write(1'b0, 2, 4'b0001, 32'h8);

    // R10: disabled line 5; R2 falling-only line 6
    bus_write(1'b0, 0, 4'b0010, 32'h0000_1000);
    pins_set(gpio | 32'h0000_0060);
    bus_read(1'b0, 2);
    chk(rd_n == 32'h0, "R10 off line and rise on falling-only line stay idle", rd_n, 32'h0);
    pins_set(gpio & ~32'h0000_0060);
    bus_read(1'b0, 2);
    chk(rd_n == 32'h40, "R2 falling-only line sets on fall", rd_n, 32'h40);

    // R8: unmapped writes ignored
    bus_write(1'b0, 3, 4'b1111, 32'hFFFF_FFFF);
    bus_write(1'b1, 5, 4'b1111, 32'h0);
    bus_write(1'b1, 2, 4'b1111, 32'h0);
    check_all("R8 after unmapped writes");

    // constrained random
    for (int it = 0; it < 300; it++) begin
      int op;
      op = int'($urandom % 4);
      case (op)
        0, 1: pins_set(gpio ^ ($urandom & $urandom));
        2: bus_write(1'b0, int'($urandom % 2), 4'($urandom), $urandom);
        default: begin
          bit rg;
          rg = 1'($urandom);
          bus_write(rg, rg ? int'($urandom % 3) : 2, 4'($urandom), $urandom | $urandom);
        end
      endcase
      check_all("random");
    end

    // R7: mirrored layout instance
    do_reset();
    bus_write(1'b0, 1, 4'b1111, 32'h0000_0002);
    pins_set(32'h0100_0000);
    bus_read(1'b0, 2);
    chk(rd_r == 32'h0000_0001, "R7 mirrored pending lane for line 24", rd_r, 32'h1);
    chk(rd_n == exp_read(1'b0, 2), "R1 default layout ignores line 24 here", rd_n, exp_read(1'b0, 2));
    chk(irq_r == 2'b11, "R7 mirrored outputs", 32'(irq_r), 32'h3);
    bus_read(1'b0, 1);
    chk(rd_r == 32'h0000_0002, "R9 mirrored trigger readback", rd_r, 32'h2);
    bus_write(1'b1, 0, 4'b0001, 32'h0000_00FE);
    chk(irq_r == 2'b10, "R7 mirrored routing lane 0 is port 3", 32'(irq_r), 32'h2);
    bus_read(1'b1, 0);
    chk(rd_r == 32'hFFFF_FFFE, "R7 mirrored mask readback", rd_r, 32'hFFFF_FFFE);

    finish_run();
  end
endmodule